// File: doc/BRIEF.md
# Transposed Column Line Buffer

This block keeps a sliding vertical window of recent video lines for a template-matching engine. One dual-port memory word exists per horizontal position in the region of interest, and each word holds a vertical stack of pixels that is as tall as the search template. When an 8-bit luma pixel arrives with its valid strobe, the block reads the stack stored at the current horizontal position and drops its oldest pixel. It puts the new pixel at the bottom, writes the stack back to the same word, and presents it on the output as a ready-made column for the matcher.

A horizontal position counter advances once per accepted pixel and wraps at the region width. A line counter advances on each wrap. Both the position and the line of the presented column leave the block next to the column. After reset every stored column reads as zero, so the columns produced during the first lines are only partly filled. Two ways of clearing the memory are available through a parameter: a per-word "filled" flag, or resetting every word directly. Their behaviour is identical.

Top module: `col_line_buf`

## Requirements
- R1: While reset is held and in the first cycle after it is released, col_valid is 0, col_x is 0 and col_line is 0.
- R2: col_valid is 1 in exactly the cycle that follows a cycle with pix_valid high, and 0 in every other cycle.
- R3: A presented column equals the column stored at that position before the update, shifted up by one pixel. The new pixel sits in bits [7:0], the pixel in byte k moves to byte k+1, and the pixel that was in byte TPL_H-1 is discarded.
- R4: col_x gives the horizontal position of the presented column. The position starts at 0, steps by one per accepted pixel, goes from ROI_W-1 back to 0, and does not move in cycles with pix_valid low.
- R5: col_line gives the line of the presented column. It starts at 0, increments after the pixel at position ROI_W-1 is accepted, wraps modulo 2^LINE_W, and holds in idle cycles.
- R6: After any reset every stored column reads as zero. A column presented during line n < TPL_H-1 after reset therefore has zero in bytes n+1 and above.
- R7: The two clearing variants (per-word filled flags, or resetting the whole array) produce identical outputs for identical input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel strobe; one pixel is accepted per high cycle |
| pix_data | input | PIX_W | Unsigned luma pixel |
| col_valid | output | 1 | Column strobe, one cycle after an accepted pixel |
| col_data | output | TPL_H*PIX_W | Updated column; newest pixel in the low byte |
| col_x | output | clog2(ROI_W) | Horizontal position of the column |
| col_line | output | LINE_W | Line count of the column, modulo 2^LINE_W |

## Verification
The bench builds two instances with ROI_W=5, TPL_H=3 and LINE_W=4, one for each clearing variant. A width of 5 is not a power of two, so the wrap at position 4 comes before the natural rollover of the 3-bit address. A column height of 3 fills after only two lines, so partial columns, full columns and the discarding of the oldest pixel all occur many times within a short run. A 4-bit line counter wraps every 80 pixels, so several line-counter wraps happen during the random phase. A reset in the middle of the run checks that memory already full of data reads as zero again.

// File: rtl/clb_pkg.sv
package clb_pkg;

   typedef enum int {
      CLB_CLR_FLAGS = 0,
      CLB_CLR_ARRAY = 1
   } clb_clr_e;

   function automatic int clb_addr_w(input int depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction

endpackage

// File: rtl/clb_hcount.sv
module clb_hcount #(
   parameter int ROI_W  = 100,
   parameter int AW     = 7,
   parameter int LINE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   output logic [AW-1:0]     addr,
   output logic [LINE_W-1:0] line
);

   localparam logic [AW-1:0] LAST = AW'(ROI_W - 1);

   logic wrap;
   assign wrap = (addr == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr <= '0;
         line <= '0;
      end else if (adv) begin
         if (wrap) begin
            addr <= '0;
            line <= line + 1'b1;
         end else begin
            addr <= addr + 1'b1;
         end
      end
   end

endmodule

// File: rtl/clb_colmem.sv
module clb_colmem #(
   parameter int                DEPTH = 100,
   parameter int                AW    = 7,
   parameter int                WIDTH = 144,
   parameter clb_pkg::clb_clr_e CLR   = clb_pkg::CLB_CLR_FLAGS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data
);

   logic [WIDTH-1:0] mem [DEPTH];

   generate
      if (CLR == clb_pkg::CLB_CLR_FLAGS) begin : g_flags
         logic [DEPTH-1:0] filled;

         always_ff @(posedge clk) begin
            if (wr_en) begin
               mem[wr_addr] <= wr_data;
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               filled <= '0;
            end else if (wr_en) begin
               filled[wr_addr] <= 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rd_data <= '0;
            end else if (rd_en) begin
               rd_data <= filled[rd_addr] ? mem[rd_addr] : '0;
            end
         end
      end else begin : g_array
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) begin
                  mem[i] <= '0;
               end
            end else if (wr_en) begin
               mem[wr_addr] <= wr_data;
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rd_data <= '0;
            end else if (rd_en) begin
               rd_data <= mem[rd_addr];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/clb_colshift.sv
module clb_colshift #(
   parameter int TPL_H = 18,
   parameter int PIX_W = 8
) (
   input  logic [TPL_H*PIX_W-1:0] col_old,
   input  logic [PIX_W-1:0]       pix,
   output logic [TPL_H*PIX_W-1:0] col_new
);

   generate
      for (genvar i = 0; i < TPL_H; i++) begin : g_lane
         if (i == 0) begin : g_newest
            assign col_new[PIX_W-1:0] = pix;
         end else begin : g_move
            assign col_new[i*PIX_W +: PIX_W] = col_old[(i-1)*PIX_W +: PIX_W];
         end
      end
   endgenerate

endmodule

// File: rtl/col_line_buf.sv
module col_line_buf #(
   parameter int                ROI_W  = 100,
   parameter int                TPL_H  = 18,
   parameter int                PIX_W  = 8,
   parameter int                LINE_W = 12,
   parameter clb_pkg::clb_clr_e CLR    = clb_pkg::CLB_CLR_FLAGS,
   localparam int               AW     = clb_pkg::clb_addr_w(ROI_W),
   localparam int               COL_W  = TPL_H * PIX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_valid,
   input  logic [PIX_W-1:0]  pix_data,
   output logic              col_valid,
   output logic [COL_W-1:0]  col_data,
   output logic [AW-1:0]     col_x,
   output logic [LINE_W-1:0] col_line
);

   generate
      if (ROI_W < 2) begin : g_bad_width
         $error("col_line_buf: ROI_W must be at least 2");
      end
      if (TPL_H < 2) begin : g_bad_height
         $error("col_line_buf: TPL_H must be at least 2");
      end
      if (PIX_W < 1) begin : g_bad_pix
         $error("col_line_buf: PIX_W must be positive");
      end
      if (LINE_W < 1) begin : g_bad_line
         $error("col_line_buf: LINE_W must be positive");
      end
   endgenerate

   logic [AW-1:0]     hc_addr;
   logic [LINE_W-1:0] hc_line;

   clb_hcount #(
      .ROI_W  (ROI_W),
      .AW     (AW),
      .LINE_W (LINE_W)
   ) u_hcount (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (pix_valid),
      .addr  (hc_addr),
      .line  (hc_line)
   );

   // Stage 1: the read is in flight; pixel and position wait beside it.
   logic              s1_v;
   logic [PIX_W-1:0]  s1_pix;
   logic [AW-1:0]     s1_addr;
   logic [LINE_W-1:0] s1_line;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s1_pix  <= '0;
         s1_addr <= '0;
         s1_line <= '0;
      end else begin
         s1_v <= pix_valid;
         if (pix_valid) begin
            s1_pix  <= pix_data;
            s1_addr <= hc_addr;
            s1_line <= hc_line;
         end
      end
   end

   logic [COL_W-1:0] rd_col;
   logic [COL_W-1:0] upd_col;

   clb_colmem #(
      .DEPTH (ROI_W),
      .AW    (AW),
      .WIDTH (COL_W),
      .CLR   (CLR)
   ) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (pix_valid),
      .rd_addr (hc_addr),
      .rd_data (rd_col),
      .wr_en   (s1_v),
      .wr_addr (s1_addr),
      .wr_data (upd_col)
   );

   clb_colshift #(
      .TPL_H (TPL_H),
      .PIX_W (PIX_W)
   ) u_shift (
      .col_old (rd_col),
      .pix     (s1_pix),
      .col_new (upd_col)
   );

   assign col_valid = s1_v;
   assign col_data  = upd_col;
   assign col_x     = s1_addr;
   assign col_line  = s1_line;

endmodule

// File: rtl/clb_checks.sv
module clb_checks #(
   parameter int ROI_W  = 100,
   parameter int TPL_H  = 18,
   parameter int PIX_W  = 8,
   parameter int LINE_W = 12,
   localparam int AW    = clb_pkg::clb_addr_w(ROI_W),
   localparam int COL_W = TPL_H * PIX_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pix_valid,
   input logic [PIX_W-1:0]  pix_data,
   input logic              col_valid,
   input logic [COL_W-1:0]  col_data,
   input logic [AW-1:0]     hc_addr,
   input logic [LINE_W-1:0] hc_line
);

   localparam logic [AW-1:0] LAST = AW'(ROI_W - 1);

   p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> col_valid);

   p_no_stray_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> !col_valid);

   p_newest_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> (col_data[PIX_W-1:0] == $past(pix_data)));

   p_addr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hc_addr <= LAST);

   p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && hc_addr != LAST) |=> (hc_addr == $past(hc_addr) + 1'b1));

   p_addr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && hc_addr == LAST) |=> (hc_addr == '0));

   p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> $stable(hc_addr));

   p_line_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && hc_addr == LAST) |=> (hc_line == $past(hc_line) + 1'b1));

   p_line_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(pix_valid && hc_addr == LAST) |=> $stable(hc_line));

endmodule

bind col_line_buf clb_checks #(
   .ROI_W  (ROI_W),
   .TPL_H  (TPL_H),
   .PIX_W  (PIX_W),
   .LINE_W (LINE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pix_valid (pix_valid),
   .pix_data  (pix_data),
   .col_valid (col_valid),
   .col_data  (col_data),
   .hc_addr   (hc_addr),
   .hc_line   (hc_line)
);

// File: tb/tb_col_line_buf.sv
module tb_col_line_buf;

   localparam int ROI_W  = 5;
   localparam int TPL_H  = 3;
   localparam int PIX_W  = 8;
   localparam int LINE_W = 4;
   localparam int AW     = clb_pkg::clb_addr_w(ROI_W);
   localparam int COL_W  = TPL_H * PIX_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              pix_valid = 1'b0;
   logic [PIX_W-1:0]  pix_data = '0;

   logic              cv_a, cv_b;
   logic [COL_W-1:0]  cd_a, cd_b;
   logic [AW-1:0]     cx_a, cx_b;
   logic [LINE_W-1:0] cl_a, cl_b;

   always #4 clk = ~clk;

   col_line_buf #(.ROI_W(ROI_W), .TPL_H(TPL_H), .PIX_W(PIX_W), .LINE_W(LINE_W),
                  .CLR(clb_pkg::CLB_CLR_FLAGS)) dut (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
      .col_valid(cv_a), .col_data(cd_a), .col_x(cx_a), .col_line(cl_a));

   col_line_buf #(.ROI_W(ROI_W), .TPL_H(TPL_H), .PIX_W(PIX_W), .LINE_W(LINE_W),
                  .CLR(clb_pkg::CLB_CLR_ARRAY)) dut_arr (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
      .col_valid(cv_b), .col_data(cd_b), .col_x(cx_b), .col_line(cl_b));

   int checks = 0;
   int errors = 0;

   // Reference model
   logic [COL_W-1:0]  m_mem [ROI_W];
   int                m_x;
   int                m_line;
   int                m_lines_since_rst;
   bit                pend;
   logic [COL_W-1:0]  pend_col;
   logic [AW-1:0]     pend_x;
   logic [LINE_W-1:0] pend_line;
   bit                pend_partial;

   function automatic logic [COL_W-1:0] shift_in(input logic [COL_W-1:0] old,
                                                 input logic [PIX_W-1:0] p);
      return {old[COL_W-PIX_W-1:0], p};
   endfunction

   task automatic chk(input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < ROI_W; i++) m_mem[i] = '0;
      m_x = 0;
      m_line = 0;
      m_lines_since_rst = 0;
      pend = 0;
   endtask

   task automatic check_outputs();
      chk("R2", "col_valid", longint'(cv_a), longint'(pend));
      chk("R7", "variant col_valid", longint'(cv_b), longint'(cv_a));
      if (pend) begin
         chk(pend_partial ? "R6" : "R3", "col_data", longint'(cd_a), longint'(pend_col));
         chk("R4", "col_x", longint'(cx_a), longint'(pend_x));
         chk("R5", "col_line", longint'(cl_a), longint'(pend_line));
         chk("R7", "variant col_data", longint'(cd_b), longint'(cd_a));
         chk("R7", "variant col_x", longint'(cx_b), longint'(cx_a));
         chk("R7", "variant col_line", longint'(cl_b), longint'(cl_a));
      end
   endtask

   task automatic step(input bit v, input logic [PIX_W-1:0] d);
      @(negedge clk);
      check_outputs();
      pix_valid = v;
      pix_data  = d;
      if (v) begin
         pend_partial = (m_lines_since_rst < TPL_H - 1);
         pend_col     = shift_in(m_mem[m_x], d);
         m_mem[m_x]   = pend_col;
         pend_x       = AW'(m_x);
         pend_line    = LINE_W'(m_line);
         pend         = 1;
         if (m_x == ROI_W - 1) begin
            m_x = 0;
            m_line = (m_line + 1) % (1 << LINE_W);
            m_lines_since_rst++;
         end else begin
            m_x++;
         end
      end else begin
         pend = 0;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      pix_valid = 1'b0;
      repeat (3) begin
         @(negedge clk);
         chk("R1", "col_valid in reset", longint'(cv_a), 0);
         chk("R1", "variant col_valid in reset", longint'(cv_b), 0);
      end
      rst_n = 1'b1;
      model_clear();
      @(negedge clk);
      chk("R1", "col_valid after reset", longint'(cv_a), 0);
      chk("R1", "col_x after reset", longint'(cx_a), 0);
      chk("R1", "col_line after reset", longint'(cl_a), 0);
      chk("R1", "variant col_x after reset", longint'(cx_b), 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R2 actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      model_clear();
      do_reset();

      // Directed: ramp without gaps, first lines give partial columns (R6), then full (R3)
      for (int i = 0; i < ROI_W * (TPL_H + 2); i++) step(1'b1, PIX_W'(i + 1));
      // Directed: idle gap keeps position and line (R4, R5)
      for (int i = 0; i < 4; i++) step(1'b0, 8'hEE);
      // Directed: extreme pixel values
      for (int i = 0; i < ROI_W * TPL_H; i++) step(1'b1, (i % 2) ? 8'hFF : 8'h00);

      // Random: gaps and data, several line-counter wraps (R5)
      for (int i = 0; i < 2000; i++) step(($urandom % 4) != 0, PIX_W'($urandom));
      step(1'b0, 8'h00);

      // Mid-run reset over a filled memory: columns read as zero again (R6)
      do_reset();
      for (int i = 0; i < ROI_W * TPL_H; i++) step(1'b1, PIX_W'($urandom));
      for (int i = 0; i < 500; i++) step(($urandom % 3) != 0, PIX_W'($urandom));
      step(1'b0, 8'h00);
      step(1'b0, 8'h00);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule